// File: doc/BRIEF.md
# Flash Command Interface and Status Register

This block is the command front end of a NOR flash die. Each accepted bus write cycle carries an 8-bit command code. The block decodes these codes into read-mode changes, status clears, and one- or two-cycle operation requests. It also tracks which kind of data a read returns: array, status, identifier or query.

Program and erase operations run in a stand-in write engine. The engine stays busy for a loadable number of clock cycles. It can be suspended and resumed, and a failure-inject input makes it finish with an error.

A status byte reports three things:
- readiness;
- the suspend state;
- sticky error flags, which only an explicit clear command removes.

The write port is a valid/ready stream that never applies back-pressure. `cmd_ready` is held high, so every cycle with `cmd_valid` high transfers one code. A code that has no meaning in the current state is consumed and dropped. The operation inputs (`busy_len`, `blk_locked`, `vpp_ok`, `fail_inject`) are sampled on the cycle that starts an operation.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array (encoding 0), the status byte is 0x80, busy is 0 and `cmd_ready` is 1.
- R2: When ready or suspended, the following codes set the read mode from the next cycle on, and nothing else changes:
  - 0xFF selects array (0);
  - 0x70 selects status (1);
  - 0x90 selects identifier (2);
  - 0x98 selects query (3).
  - Unknown codes are dropped.
- R3: Code 0x40 (word program) or 0xC0 (protection program) switches the read mode to status. The following write cycle, whatever its value, is taken as data and starts a program.
- R4: An operation stays busy for N cycles after its starting edge, where N is `busy_len`, or 1 when `busy_len` is 0. While busy, status bit 7 is 0 and bits 6..1 read as 0. Bit 7 equals the inverse of `busy`.
- R5: Both of these start an operation:
  - 0x20 followed by 0xD0 starts a block erase;
  - 0xE8 followed by 0xD0 starts a buffered program.
- R6: If the second cycle after 0x20 or 0xE8 is not 0xD0, status bits 5 and 4 are set, with bit 7 staying 1, and no operation starts.
- R7: If `fail_inject` is high when an operation starts, completion sets bit 4 for a program or buffered program, or bit 5 for an erase.
- R8: At start, two conditions refuse the operation. In both cases no busy period follows.
  - `blk_locked` high sets bit 1 together with the operation's bit (4 or 5).
  - `vpp_ok` low sets bit 3 together with the operation's bit.
- R9: Error bits 5, 4, 3 and 1 stay set across later commands and operations. Only 0x50, issued while ready or suspended, clears them, and 0x50 leaves the read mode unchanged.
- R10: Code 0xB0 during a busy program suspends it: bit 2 is set and busy drops. During a busy erase it sets bit 6 instead. The busy counter freezes while suspended. 0xD0 resumes the operation, sets read mode to status and runs the remaining cycles, so the total busy time is still N. 0xB0 while ready is ignored.
- R11: While busy, every code except 0xB0 is ignored, and the read mode holds.
- R12: While suspended, 0x20 and the write that follows it are both dropped, so a following 0xD0 does not resume. Program and setup codes are also dropped while suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Write cycle present |
| cmd_ready | output | 1 | Always 1; a write transfers whenever `cmd_valid` is high |
| cmd_code | input | 8 | Command code or program data |
| busy_len | input | CNT_W | Busy duration in cycles, sampled at start |
| blk_locked | input | 1 | Target block is locked, sampled at start |
| vpp_ok | input | 1 | Program supply valid, sampled at start |
| fail_inject | input | 1 | Finish the operation with an error, sampled at start |
| read_mode | output | 2 | 0 array, 1 status, 2 identifier, 3 query |
| status | output | 8 | Status byte |
| busy | output | 1 | Write engine running |

## Verification
The bench targets several corner cases:
- A bad confirm code. A design that ignored it would silently return to ready with clean status.
- An error left standing across a read-mode change and a new program. A design that cleared it on a new command would lose bits 5 and 4.
- A suspend in the middle of a program. The bench counts busy cycles before the suspend and after the resume; a counter that kept running or reloaded while suspended would finish early or late.
- An erase-setup and 0xD0 pair issued while suspended. A design without the interlock would resume.
- A zero busy length, and `fail_inject` dropped right after the starting edge. These expose a design that decrements to an underflow or samples the fault flag late.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

  localparam logic [7:0] CODE_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CODE_RD_STATUS = 8'h70;
  localparam logic [7:0] CODE_RD_IDENT  = 8'h90;
  localparam logic [7:0] CODE_RD_QUERY  = 8'h98;
  localparam logic [7:0] CODE_CLEAR     = 8'h50;
  localparam logic [7:0] CODE_WORD_PROG = 8'h40;
  localparam logic [7:0] CODE_OTP_PROG  = 8'hC0;
  localparam logic [7:0] CODE_ERASE     = 8'h20;
  localparam logic [7:0] CODE_BUF_PROG  = 8'hE8;
  localparam logic [7:0] CODE_SUSPEND   = 8'hB0;
  localparam logic [7:0] CODE_CONFIRM   = 8'hD0;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_IDENT  = 2'd2,
    RM_QUERY  = 2'd3
  } rd_mode_t;

  typedef enum logic [3:0] {
    CK_NONE, CK_RD_ARRAY, CK_RD_STAT, CK_RD_ID, CK_QUERY, CK_CLEAR,
    CK_PROG, CK_ERASE, CK_BUF, CK_SUSP, CK_CONFIRM
  } cmd_kind_t;

  typedef enum logic [2:0] {
    ST_READY, ST_PSETUP, ST_ESETUP, ST_BSETUP,
    ST_PBUSY, ST_EBUSY, ST_PSUSP, ST_ESUSP
  } ctl_state_t;

  // sticky error flag slots
  localparam int ERR_N     = 4;
  localparam int ERR_LOCK  = 0;  // status bit 1
  localparam int ERR_VPP   = 1;  // status bit 3
  localparam int ERR_PROG  = 2;  // status bit 4
  localparam int ERR_ERASE = 3;  // status bit 5

endpackage

// File: rtl/cmd_decode.sv
`timescale 1ns/1ps
module cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic [7:0] code,
  output cmd_kind_t  kind
);
  always_comb begin
    unique case (code)
      CODE_RD_ARRAY:  kind = CK_RD_ARRAY;
      CODE_RD_STATUS: kind = CK_RD_STAT;
      CODE_RD_IDENT:  kind = CK_RD_ID;
      CODE_RD_QUERY:  kind = CK_QUERY;
      CODE_CLEAR:     kind = CK_CLEAR;
      CODE_WORD_PROG: kind = CK_PROG;
      CODE_OTP_PROG:  kind = CK_PROG;
      CODE_ERASE:     kind = CK_ERASE;
      CODE_BUF_PROG:  kind = CK_BUF;
      CODE_SUSPEND:   kind = CK_SUSP;
      CODE_CONFIRM:   kind = CK_CONFIRM;
      default:        kind = CK_NONE;
    endcase
  end
endmodule

// File: rtl/wsm_timer.sv
`timescale 1ns/1ps
module wsm_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             run,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= (len == '0) ? ONE : len;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end

  assign done = run && (cnt_q == ONE);
endmodule

// File: rtl/sticky_bits.sv
`timescale 1ns/1ps
module sticky_bits #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr)    q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_code,
  input  logic [CNT_W-1:0] busy_len,
  input  logic             blk_locked,
  input  logic             vpp_ok,
  input  logic             fail_inject,
  output logic [1:0]       read_mode,
  output logic [7:0]       status,
  output logic             busy
);
  ctl_state_t       st_q, st_d;
  rd_mode_t         mode_q, mode_d;
  logic             swallow_q, swallow_d;
  logic             fail_q, fail_d;
  cmd_kind_t        kind;
  logic             acc;
  logic [ERR_N-1:0] err_q, err_set;
  logic             err_clr;
  logic             t_load, t_run, t_done;
  logic             start, start_erase;
  logic             op_bit_prog, op_bit_erase;

  assign cmd_ready = 1'b1;
  assign acc       = cmd_valid && cmd_ready;

  cmd_decode u_dec (.code(cmd_code), .kind(kind));

  wsm_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(t_load), .len(busy_len),
    .run(t_run), .done(t_done)
  );

  sticky_bits #(.N(ERR_N)) u_err (
    .clk(clk), .rst_n(rst_n), .set(err_set), .clr(err_clr), .q(err_q)
  );

  assign t_run = (st_q == ST_PBUSY) || (st_q == ST_EBUSY);

  always_comb begin
    st_d        = st_q;
    mode_d      = mode_q;
    swallow_d   = swallow_q;
    fail_d      = fail_q;
    err_set     = '0;
    err_clr     = 1'b0;
    t_load      = 1'b0;
    start       = 1'b0;
    start_erase = 1'b0;

    unique case (st_q)
      ST_READY: if (acc) begin
        unique case (kind)
          CK_RD_ARRAY: mode_d = RM_ARRAY;
          CK_RD_STAT:  mode_d = RM_STATUS;
          CK_RD_ID:    mode_d = RM_IDENT;
          CK_QUERY:    mode_d = RM_QUERY;
          CK_CLEAR:    err_clr = 1'b1;
          CK_PROG:     begin st_d = ST_PSETUP; mode_d = RM_STATUS; end
          CK_ERASE:    begin st_d = ST_ESETUP; mode_d = RM_STATUS; end
          CK_BUF:      begin st_d = ST_BSETUP; mode_d = RM_STATUS; end
          default:     ;
        endcase
      end
      ST_PSETUP: if (acc) start = 1'b1;
      ST_ESETUP, ST_BSETUP: if (acc) begin
        if (kind == CK_CONFIRM) begin
          start       = 1'b1;
          start_erase = (st_q == ST_ESETUP);
        end else begin
          err_set[ERR_ERASE] = 1'b1;
          err_set[ERR_PROG]  = 1'b1;
          st_d               = ST_READY;
        end
      end
      ST_PBUSY, ST_EBUSY: begin
        if (t_done) begin
          st_d = ST_READY;
          if (fail_q) begin
            err_set[ERR_PROG]  = (st_q == ST_PBUSY);
            err_set[ERR_ERASE] = (st_q == ST_EBUSY);
          end
        end else if (acc && kind == CK_SUSP) begin
          st_d = (st_q == ST_PBUSY) ? ST_PSUSP : ST_ESUSP;
        end
      end
      ST_PSUSP, ST_ESUSP: if (acc) begin
        if (swallow_q) begin
          swallow_d = 1'b0;
        end else begin
          unique case (kind)
            CK_RD_ARRAY: mode_d = RM_ARRAY;
            CK_RD_STAT:  mode_d = RM_STATUS;
            CK_RD_ID:    mode_d = RM_IDENT;
            CK_QUERY:    mode_d = RM_QUERY;
            CK_CLEAR:    err_clr = 1'b1;
            CK_ERASE:    swallow_d = 1'b1;
            CK_CONFIRM: begin
              st_d   = (st_q == ST_PSUSP) ? ST_PBUSY : ST_EBUSY;
              mode_d = RM_STATUS;
            end
            default:     ;
          endcase
        end
      end
      default: st_d = ST_READY;
    endcase

    op_bit_prog  = start && !start_erase;
    op_bit_erase = start && start_erase;

    if (start) begin
      if (blk_locked || !vpp_ok) begin
        err_set[ERR_LOCK]  = blk_locked;
        err_set[ERR_VPP]   = !vpp_ok;
        err_set[ERR_PROG]  = op_bit_prog;
        err_set[ERR_ERASE] = op_bit_erase;
        st_d               = ST_READY;
      end else begin
        t_load = 1'b1;
        fail_d = fail_inject;
        st_d   = start_erase ? ST_EBUSY : ST_PBUSY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_READY;
      mode_q    <= RM_ARRAY;
      swallow_q <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      mode_q    <= mode_d;
      swallow_q <= swallow_d;
      fail_q    <= fail_d;
    end
  end

  assign busy      = t_run;
  assign read_mode = mode_q;
  assign status    = busy ? 8'h00 :
                     {1'b1, st_q == ST_ESUSP, err_q[ERR_ERASE], err_q[ERR_PROG],
                      err_q[ERR_VPP], st_q == ST_PSUSP, err_q[ERR_LOCK], 1'b0};
endmodule

// File: rtl/flash_cmd_chk.sv
`timescale 1ns/1ps
module flash_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_code,
  input logic [1:0] read_mode,
  input logic [7:0] status,
  input logic       busy
);
  // R4: ready flag mirrors the engine activity
  a_r4_ready_flag: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] == !busy);

  // R4: lower bits hidden while busy
  a_r4_mask_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status[6:0] == 7'h00);

  // R10: never both suspend flags
  a_r10_susp_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[6] && status[2]));

  // R11: read mode holds across busy cycles
  a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(read_mode));

  // R9: program error bit survives anything but a clear
  a_r9_sticky_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && status[4] && !(cmd_valid && cmd_code == 8'h50)) |=> (busy || status[4]));

  // R9: erase error bit survives anything but a clear
  a_r9_sticky_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && status[5] && !(cmd_valid && cmd_code == 8'h50)) |=> (busy || status[5]));
endmodule

bind flash_cmd_ctrl flash_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .read_mode(read_mode), .status(status), .busy(busy)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [7:0]       cmd_code = 8'h00;
  logic [CNT_W-1:0] busy_len = 16'd3;
  logic             blk_locked = 1'b0;
  logic             vpp_ok = 1'b1;
  logic             fail_inject = 1'b0;
  logic [1:0]       read_mode;
  logic [7:0]       status;
  logic             busy;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .busy_len(busy_len), .blk_locked(blk_locked),
    .vpp_ok(vpp_ok), .fail_inject(fail_inject), .read_mode(read_mode),
    .status(status), .busy(busy)
  );

  typedef struct {
    string      tag;
    logic [1:0] mode;
    logic [7:0] st;
    logic       bsy;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   all_done = 1'b0;

  task automatic expect_out(string tag, logic [1:0] m, logic [7:0] s, logic b);
    exp_t e;
    e.tag = tag; e.mode = m; e.st = s; e.bsy = b;
    exp_q.push_back(e);
  endtask

  task automatic wr(logic [7:0] c);
    cmd_valid = 1'b1;
    cmd_code  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = 8'h00;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      n_chk++;
      if (read_mode !== e.mode || status !== e.st || busy !== e.bsy || cmd_ready !== 1'b1) begin
        n_bad++;
        $display("FAIL %s: mode=%0d status=%02h busy=%0b ready=%0b expected mode=%0d status=%02h busy=%0b ready=1",
                 e.tag, read_mode, status, busy, cmd_ready, e.mode, e.st, e.bsy);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!all_done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    expect_out("R1 reset", 2'd0, 8'h80, 1'b0);

    // R2 read-mode codes
    wr(8'h70); expect_out("R2 status mode", 2'd1, 8'h80, 1'b0);
    wr(8'h90); expect_out("R2 ident mode",  2'd2, 8'h80, 1'b0);
    wr(8'h98); expect_out("R2 query mode",  2'd3, 8'h80, 1'b0);
    wr(8'hFF); expect_out("R2 array mode",  2'd0, 8'h80, 1'b0);
    wr(8'h12); expect_out("R2 unknown dropped", 2'd0, 8'h80, 1'b0);

    // R3/R4 word program, N=3
    busy_len = 16'd3;
    wr(8'h40); expect_out("R3 setup to status", 2'd1, 8'h80, 1'b0);
    wr(8'hAB); expect_out("R4 busy after data", 2'd1, 8'h00, 1'b1);
    idle(2);   expect_out("R4 busy at N-1", 2'd1, 8'h00, 1'b1);
    idle(1);   expect_out("R4 ready at N", 2'd1, 8'h80, 1'b0);

    // R11 codes ignored while busy, N=4
    busy_len = 16'd4;
    wr(8'hFF); wr(8'hC0); wr(8'h00);
    expect_out("R3 otp program busy", 2'd1, 8'h00, 1'b1);
    wr(8'hFF); expect_out("R11 ignore while busy", 2'd1, 8'h00, 1'b1);
    wr(8'h50); idle(1); expect_out("R11 still busy", 2'd1, 8'h00, 1'b1);
    idle(1);   expect_out("R11 done, mode held", 2'd1, 8'h80, 1'b0);

    // R5 erase and buffered program, N=2
    busy_len = 16'd2;
    wr(8'h20); wr(8'hD0); expect_out("R5 erase busy", 2'd1, 8'h00, 1'b1);
    idle(1);   expect_out("R5 erase busy 2", 2'd1, 8'h00, 1'b1);
    idle(1);   expect_out("R5 erase done", 2'd1, 8'h80, 1'b0);
    wr(8'hE8); wr(8'hD0); expect_out("R5 buffered busy", 2'd1, 8'h00, 1'b1);
    idle(2);   expect_out("R5 buffered done", 2'd1, 8'h80, 1'b0);

    // R6 bad confirm, R9 stickiness
    wr(8'h20); wr(8'h55); expect_out("R6 erase bad confirm", 2'd1, 8'hB0, 1'b0);
    wr(8'hFF); expect_out("R9 kept over mode change", 2'd0, 8'hB0, 1'b0);
    wr(8'h40); wr(8'h01); idle(2);
    expect_out("R9 kept over program", 2'd1, 8'hB0, 1'b0);
    wr(8'h50); expect_out("R9 clear keeps mode", 2'd1, 8'h80, 1'b0);
    wr(8'hE8); wr(8'hFF); expect_out("R6 buffered bad confirm", 2'd1, 8'hB0, 1'b0);
    wr(8'h50);

    // R7 fail inject sampled at start
    fail_inject = 1'b1;
    wr(8'h40); wr(8'h00);
    fail_inject = 1'b0;
    idle(2);   expect_out("R7 program failure", 2'd1, 8'h90, 1'b0);
    wr(8'h50);
    fail_inject = 1'b1;
    wr(8'h20); wr(8'hD0);
    fail_inject = 1'b0;
    idle(2);   expect_out("R7 erase failure", 2'd1, 8'hA0, 1'b0);
    wr(8'h50);

    // R8 refused starts
    blk_locked = 1'b1;
    wr(8'h40); wr(8'h00); expect_out("R8 locked program", 2'd1, 8'h92, 1'b0);
    blk_locked = 1'b0;
    wr(8'h50);
    vpp_ok = 1'b0;
    wr(8'h20); wr(8'hD0); expect_out("R8 supply fault erase", 2'd1, 8'hA8, 1'b0);
    vpp_ok = 1'b1;
    wr(8'h50); expect_out("R9 clear all", 2'd1, 8'h80, 1'b0);

    // R10/R12 program suspend, N=6
    busy_len = 16'd6;
    wr(8'h40); wr(8'h00);
    idle(1);
    wr(8'hB0); expect_out("R10 program suspended", 2'd1, 8'h84, 1'b0);
    idle(3);   expect_out("R10 frozen", 2'd1, 8'h84, 1'b0);
    wr(8'h20); wr(8'hD0); expect_out("R12 pair ignored", 2'd1, 8'h84, 1'b0);
    wr(8'h40); expect_out("R12 program dropped", 2'd1, 8'h84, 1'b0);
    wr(8'h90); expect_out("R2 mode in suspend", 2'd2, 8'h84, 1'b0);
    wr(8'hD0); expect_out("R10 resumed", 2'd1, 8'h00, 1'b1);
    idle(3);   expect_out("R10 remaining cycles", 2'd1, 8'h00, 1'b1);
    idle(1);   expect_out("R10 total N", 2'd1, 8'h80, 1'b0);

    // R10 erase suspend, N=4
    busy_len = 16'd4;
    wr(8'h20); wr(8'hD0);
    wr(8'hB0); expect_out("R10 erase suspended", 2'd1, 8'hC0, 1'b0);
    wr(8'hD0); expect_out("R10 erase resumed", 2'd1, 8'h00, 1'b1);
    idle(2);   expect_out("R10 erase remaining", 2'd1, 8'h00, 1'b1);
    idle(1);   expect_out("R10 erase complete", 2'd1, 8'h80, 1'b0);
    wr(8'hB0); expect_out("R10 suspend when ready ignored", 2'd1, 8'h80, 1'b0);

    // R4 zero length means one cycle
    busy_len = 16'd0;
    wr(8'h40); wr(8'h00); expect_out("R4 zero length busy", 2'd1, 8'h00, 1'b1);
    idle(1);   expect_out("R4 zero length done", 2'd1, 8'h80, 1'b0);

    wait (exp_q.size() == 0);
    #1;
    all_done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule